// File: doc/BRIEF.md
# Serial Wiper Command Front End

This block sits between a three-wire serial host link and a digitally controlled resistor wiper. The host raises chip-select, then clocks bits in on the serial clock. Each frame opens with a start bit, continues with an operation code and an address byte, and may end with a wiper data phase. The block keeps the 7-bit wiper position and presents it on a parallel output that selects the resistor tap. It also keeps a write-enable latch. The latch is cleared at power-up, and it decides whether a wiper write is accepted.

The single data pin is split into pad-side signals: `dio_in` from the pad, and `dio_out` with its enable `dio_oe` toward the pad. A low `dio_oe` means the pin is high-impedance. On a read command the block turns the pin around for exactly seven data slots and then releases it. All inputs are sampled by the block's own clock, which must run much faster than the serial clock.

Top module: `wiper_serial_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, the wiper position is 0 and `dio_oe` is low.
- R2: A wiper write frame has no effect on the wiper position while the write-enable latch is clear.
- R3: The write-enable latch stays set across any number of frames until a disable frame or a reset clears it.
- R4: The 8 address bits of enable and disable frames have no effect on what those commands do.
- R5: Serial clocks after the 16th in an enable or disable frame change no state, including bit patterns that look like a new command.
- R6: A read frame (opcode 1010000) drives wiper bits 0 to 6, lowest bit first, in frame slots 17 to 23. Slot 1 is the start bit.
- R7: `dio_oe` is low during slots 1 to 16 of a read frame and again from slot 24 on.
- R8: `dio_out` and `dio_oe` change only after a falling serial clock edge or on chip-select deassertion, so they hold steady while the serial clock is high.
- R9: Dropping chip-select mid-frame releases the pin and aborts the frame. The latch and the wiper keep their values.
- R10: Bits clocked while idle before the first 1 are ignored. That first 1 is the start bit.
- R11: Unknown opcodes change no state. The known opcodes, sent most significant bit first, are enable 0110000, disable 0100000, read 1010000 and write 1100000.
- R12: When the latch is set, a write frame (opcode 1100000) loads the 7 bits clocked in slots 17 to 23, lowest bit first, into the wiper.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset, acts as power-on |
| cs | input | 1 | Chip-select, active high |
| sclk | input | 1 | Serial clock |
| dio_in | input | 1 | Data pin, pad to block |
| dio_out | output | 1 | Data pin, block to pad |
| dio_oe | output | 1 | Drive enable for the data pin; low means high-impedance |
| wiper_pos | output | 7 | Current wiper tap position |

## Verification
The assertions assume that `cs`, `sclk` and `dio_in` change in step with the block clock, and that each serial clock level lasts at least three block clocks, so that every serial edge gives exactly one edge pulse. The bench drives every input on the falling block clock edge and holds each serial clock level for six block cycles. It changes `cs` only while the serial clock is low, so the rules of the edge detector are never broken.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int OP_W = 7;

    localparam logic [OP_W-1:0] OPC_WREN  = 7'b0110000;
    localparam logic [OP_W-1:0] OPC_WRDI  = 7'b0100000;
    localparam logic [OP_W-1:0] OPC_READ  = 7'b1010000;
    localparam logic [OP_W-1:0] OPC_WRITE = 7'b1100000;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_HDR,
        FS_RDAT,
        FS_WDAT,
        FS_DONE
    } frame_st_e;

    typedef struct packed {
        logic wel_set;
        logic wel_clr;
        logic wr;
    } reg_req_t;

    function automatic cmd_e op_decode(input logic [OP_W-1:0] op);
        cmd_e c;
        case (op)
            OPC_WREN:  c = CMD_WREN;
            OPC_WRDI:  c = CMD_WRDI;
            OPC_READ:  c = CMD_READ;
            OPC_WRITE: c = CMD_WRITE;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wsc_in_stage.sv
module wsc_in_stage (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    output logic cs_q,
    output logic din_q,
    output logic rise,
    output logic fall
);
    logic [1:0] sclk_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sh <= '0;
            cs_q    <= 1'b0;
            din_q   <= 1'b0;
        end else begin
            sclk_sh <= {sclk_sh[0], sclk};
            cs_q    <= cs;
            din_q   <= din;
        end
    end

    assign rise = sclk_sh[0] & ~sclk_sh[1];
    assign fall = ~sclk_sh[0] & sclk_sh[1];

endmodule

// File: rtl/wsc_frame.sv
module wsc_frame
    import wsc_pkg::*;
#(
    parameter int WIPER_W = 7,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs,
    input  logic               din,
    input  logic               rise,
    input  logic               fall,
    input  logic [WIPER_W-1:0] wiper,
    output reg_req_t           req,
    output logic [WIPER_W-1:0] wdata,
    output logic               dout,
    output logic               oe
);
    localparam int HDR_BITS = OP_W + ADDR_W;
    localparam int CNT_MAX  = (HDR_BITS > WIPER_W) ? HDR_BITS : WIPER_W;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] OP_CNT   = CNT_W'(OP_W);
    localparam logic [CNT_W-1:0] WP_CNT   = CNT_W'(WIPER_W);
    localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WIPER_W - 1);

    frame_st_e          st;
    logic [CNT_W-1:0]   cnt;
    logic [OP_W-1:0]    op;
    logic [WIPER_W-1:0] rsh;
    logic [WIPER_W-1:0] wsh;

    always_ff @(posedge clk) begin
        if (rst || !cs) begin
            st   <= FS_IDLE;
            cnt  <= '0;
            op   <= '0;
            rsh  <= '0;
            oe   <= 1'b0;
            dout <= 1'b0;
            req  <= '0;
            if (rst) wsh <= '0;
        end else begin
            req <= '0;
            case (st)
                FS_IDLE: begin
                    if (rise && din) begin
                        st  <= FS_HDR;
                        cnt <= '0;
                    end
                end
                FS_HDR: begin
                    if (rise) begin
                        if (cnt < OP_CNT) op <= {op[OP_W-2:0], din};
                        cnt <= cnt + 1'b1;
                        if (cnt == HDR_LAST) begin
                            cnt <= '0;
                            case (op_decode(op))
                                CMD_WREN:  begin req.wel_set <= 1'b1; st <= FS_DONE; end
                                CMD_WRDI:  begin req.wel_clr <= 1'b1; st <= FS_DONE; end
                                CMD_READ:  begin rsh <= wiper; st <= FS_RDAT; end
                                CMD_WRITE: st <= FS_WDAT;
                                default:   st <= FS_DONE;
                            endcase
                        end
                    end
                end
                FS_RDAT: begin
                    if (fall) begin
                        if (cnt < WP_CNT) begin
                            oe   <= 1'b1;
                            dout <= rsh[0];
                            rsh  <= {1'b0, rsh[WIPER_W-1:1]};
                            cnt  <= cnt + 1'b1;
                        end else begin
                            oe   <= 1'b0;
                            dout <= 1'b0;
                            st   <= FS_DONE;
                        end
                    end
                end
                FS_WDAT: begin
                    if (rise) begin
                        wsh <= {din, wsh[WIPER_W-1:1]};
                        cnt <= cnt + 1'b1;
                        if (cnt == WP_LAST) begin
                            req.wr <= 1'b1;
                            st     <= FS_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign wdata = wsh;

    AST_OE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        oe |-> (st == FS_RDAT) && (cnt != '0));                        // R7

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable({oe, dout}) |-> ($past(fall) || !$past(cs)));         // R8

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !oe);                                                  // R9

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req));                                                // R11

endmodule

// File: rtl/wsc_regs.sv
module wsc_regs
    import wsc_pkg::*;
#(
    parameter int WIPER_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_req_t           req,
    input  logic [WIPER_W-1:0] wdata,
    output logic               wel,
    output logic [WIPER_W-1:0] wiper
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            wel   <= 1'b0;
            wiper <= '0;
        end else begin
            if (req.wel_clr)      wel <= 1'b0;
            else if (req.wel_set) wel <= 1'b1;
            if (req.wr && wel) wiper <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            AST_RST_CLEAR: assert (!wel && wiper == '0);               // R1
    end

    AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper) |-> $past(wel));                               // R2

    AST_WEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(wel) && !$past(req.wel_clr) |-> wel);                    // R3

endmodule

// File: rtl/wiper_serial_ctrl.sv
module wiper_serial_ctrl
    import wsc_pkg::*;
#(
    parameter int WIPER_W = 7,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs,
    input  logic               sclk,
    input  logic               dio_in,
    output logic               dio_out,
    output logic               dio_oe,
    output logic [WIPER_W-1:0] wiper_pos
);
    logic               cs_q, din_q, rise, fall, wel;
    reg_req_t           req;
    logic [WIPER_W-1:0] wdata;

    wsc_in_stage u_in (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .din(dio_in),
        .cs_q(cs_q), .din_q(din_q), .rise(rise), .fall(fall)
    );

    wsc_frame #(.WIPER_W(WIPER_W), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst(rst), .cs(cs_q), .din(din_q), .rise(rise), .fall(fall),
        .wiper(wiper_pos), .req(req), .wdata(wdata), .dout(dio_out), .oe(dio_oe)
    );

    wsc_regs #(.WIPER_W(WIPER_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .wdata(wdata),
        .wel(wel), .wiper(wiper_pos)
    );

    AST_WEL_NOT_OUT: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !dio_oe);                                       // R5

endmodule

// File: tb/sim_wiper_serial_ctrl.sv
`timescale 1ns/1ps
module sim_wiper_serial_ctrl;
    localparam logic [6:0] OP_EN = 7'b0110000;
    localparam logic [6:0] OP_DI = 7'b0100000;
    localparam logic [6:0] OP_RD = 7'b1010000;
    localparam logic [6:0] OP_WR = 7'b1100000;
    localparam logic [6:0] OP_XX = 7'b1110000;

    logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, din = 1'b0;
    logic dout, oe;
    logic [6:0] wpos;
    int checks = 0, fails = 0, hold_err = 0, win_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wiper_serial_ctrl u0 (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .dio_in(din),
        .dio_out(dout), .dio_oe(oe), .wiper_pos(wpos)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic b, output logic s_oe, output logic s_d);
        @(negedge clk); sclk = 1'b0; din = b;
        repeat (6) @(negedge clk);
        s_oe = oe; s_d = dout;
        sclk = 1'b1;
        repeat (6) @(negedge clk);
        if (oe !== s_oe || dout !== s_d) hold_err++;
    endtask

    task automatic hdr(input logic [6:0] op, input logic [7:0] addr);
        logic a, b;
        tick(1'b1, a, b);
        if (a) win_err++;
        for (int i = 6; i >= 0; i--) begin tick(op[i], a, b); if (a) win_err++; end
        for (int i = 0; i < 8; i++) begin tick(addr[i], a, b); if (a) win_err++; end
    endtask

    task automatic cs_on();
        @(negedge clk); sclk = 1'b0; cs = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk); sclk = 1'b0; cs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd(input logic [6:0] op, input logic [7:0] addr, input int extra,
                       input logic [31:0] pat);
        logic a, b;
        cs_on(); hdr(op, addr);
        for (int i = 0; i < extra; i++) tick(pat[i % 32], a, b);
        cs_off();
    endtask

    task automatic wr(input logic [6:0] v);
        logic a, b;
        cs_on(); hdr(OP_WR, 8'h3C);
        for (int i = 0; i < 7; i++) tick(v[i], a, b);
        cs_off();
    endtask

    task automatic rd(output logic [6:0] v);
        logic a, b;
        cs_on(); hdr(OP_RD, 8'h00);
        for (int i = 0; i < 7; i++) begin
            tick(1'b0, a, b);
            v[i] = b;
            if (a !== 1'b1) win_err++;
        end
        tick(1'b0, a, b);
        if (a !== 1'b0) win_err++;
        cs_off();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [6:0] v;
        logic a, b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", int'(oe), 0);
        chk("R1 wiper after reset", int'(wpos), 0);
        rd(v);
        chk("R1 read after reset", int'(v), 0);
        chk("R7 read window", win_err, 0);

        wr(7'h55);
        chk("R2 write without enable", int'(wpos), 0);

        // R10: idle zeros before the start bit
        cs_on();
        for (int i = 0; i < 3; i++) tick(1'b0, a, b);
        hdr(OP_EN, 8'h00);
        cs_off();
        wr(7'h2A);
        chk("R10 leading zeros ignored", int'(wpos), 'h2A);
        chk("R12 write after enable", int'(wpos), 'h2A);

        // R6 R12 R3: sweep every wiper value with latch kept set
        for (int k = 0; k < 128; k++) begin
            wr(7'(k));
            rd(v);
            chk("R6 read back", int'(v), k);
            chk("R12 tap output", int'(wpos), k);
        end
        chk("R3 latch held over sweep", int'(wpos), 127);
        chk("R7 pin window over sweep", win_err, 0);

        // R4: address does not matter
        cmd(OP_DI, 8'hFF, 0, 0);
        wr(7'd5);
        chk("R4 disable with address FF", int'(wpos), 127);
        chk("R3 disable clears latch", int'(wpos), 127);
        cmd(OP_EN, 8'hA5, 0, 0);
        wr(7'd9);
        chk("R4 enable with address A5", int'(wpos), 9);

        // R5: trailing clocks ignored
        cmd(OP_EN, 8'h00, 30, 32'hFFFF_FFFF);
        chk("R5 extra clocks after enable", int'(wpos), 9);
        cmd(OP_DI, 8'h00, 24, {8'h0, 16'h0, 1'b0, 7'b0000110, 1'b1});
        wr(7'd3);
        chk("R5 extra clocks after disable", int'(wpos), 9);

        // R11: unknown opcode
        cmd(OP_EN, 8'h00, 0, 0);
        cmd(OP_XX, 8'h00, 7, 32'h0000_0015);
        chk("R11 unknown opcode wiper", int'(wpos), 9);
        wr(7'd4);
        chk("R11 unknown opcode latch", int'(wpos), 4);

        // R9: abort read mid data phase
        cs_on(); hdr(OP_RD, 8'h00);
        for (int i = 0; i < 3; i++) tick(1'b0, a, b);
        chk("R9 pin driven before abort", int'(a), 1);
        cs_off();
        chk("R9 pin released on abort", int'(oe), 0);
        // R9: abort write mid data phase
        cs_on(); hdr(OP_WR, 8'h00);
        for (int i = 0; i < 5; i++) tick(1'b1, a, b);
        cs_off();
        chk("R9 aborted write", int'(wpos), 4);
        wr(7'd77);
        chk("R9 latch kept after abort", int'(wpos), 77);

        // R1: reset clears latch and wiper
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 wiper after second reset", int'(wpos), 0);
        wr(7'd33);
        chk("R1 latch cleared by reset", int'(wpos), 0);

        chk("R8 outputs steady while sclk high", hold_err, 0);
        chk("R7 pin window overall", win_err, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule